// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This block moves the bits of a data word by a variable distance and reports the bit that left the word. It covers left and right logical shifts, an arithmetic right shift that keeps the sign, rotates left and right within the word, and rotates left and right through the carry, where the carry acts as one more bit in a loop one wider than the word. The block takes the operand, a count, an operation code and the current carry flag. It returns the moved word, the new carry flag and an overflow flag for left shifts.

The count can come from an instruction's immediate field or from a register. Only its low bits are decoded. The datapath between the inputs and the outputs is pure combinational logic. A single output register stage holds the result, so each set of inputs shows up on the outputs one clock edge later. The block has no flag storage and no sequencing. The surrounding pipeline keeps the carry and feeds it back.

Top module: `shrot_unit`

## Requirements
- R1: All outputs are registered. While `rst` is high at a rising edge, `result_o`, `carry_o` and `ovf_o` become zero. Otherwise the values for the inputs present at a rising edge appear on the outputs just after that edge.
- R2: An effective count of zero gives `result_o` equal to the operand, `carry_o` equal to `carry_i` and `ovf_o` zero, for every operation code.
- R3: Only the low 6 bits of `count_i` are decoded, so the upper 2 bits have no effect. For example, a count of 0x41 acts as 1 and 0x40 acts as 0.
- R4: Operation code 0 shifts left logically and code 1 shifts right logically. Vacated bits are zero and `carry_o` is the last bit shifted out. A count of 32 gives a zero result with carry equal to bit 0 (left) or bit 31 (right). Counts of 33 to 63 give a zero result and a zero carry.
- R5: Operation code 2 shifts right arithmetically. Vacated high bits copy bit 31 and `carry_o` is the last bit shifted out. Counts of 32 to 63 give all bits equal to bit 31, and the carry also equals bit 31.
- R6: Operation code 3 rotates left and code 4 rotates right, within 32 bits, by the count modulo 32. `carry_o` is the last bit moved around, which is bit 0 of the result for left and bit 31 of the result for right.
- R7: Operation code 5 rotates left and code 6 rotates right through the carry. The 33-bit value {carry_i, operand} is rotated by the count modulo 33. `result_o` takes the low 32 bits and `carry_o` takes the top bit.
- R8: For code 0 with a nonzero count, `ovf_o` is 1 when any bit shifted out, or bit 31 of the result, differs from bit 31 of the operand. For every other code, `ovf_o` is 0.
- R9: Operation code 7 passes the operand through unchanged, keeps `carry_i` and gives `ovf_o` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| operand_i | input | 32 | Word to shift or rotate |
| count_i | input | 8 | Shift or rotate distance; low 6 bits used |
| op_i | input | 3 | Operation code (0..7) |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 32 | Registered moved word |
| carry_o | output | 1 | Registered new carry flag |
| ovf_o | output | 1 | Registered left-shift overflow flag |

## Verification
The bench uses directed words for the boundary cases. Sign-set and sign-clear operands at counts 31, 32, 33 and 63 show whether saturation and the carry are handled differently between the logical and arithmetic shifts. Rotates by 32 and by 33 show whether the plain rotates loop over 32 bits and the carry rotates over 33. Counts of 0x40 and 0x41 show whether the upper count bits are ignored. Many pseudo-random operands, carries and counts then compare every operation code against a reference model that moves one bit per step.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  localparam int unsigned OP_W = 3;
  typedef enum logic [OP_W-1:0] {
    OP_SHL  = 3'd0,
    OP_SHR  = 3'd1,
    OP_SAR  = 3'd2,
    OP_ROTL = 3'd3,
    OP_ROTR = 3'd4,
    OP_RCL  = 3'd5,
    OP_RCR  = 3'd6,
    OP_PASS = 3'd7
  } shrot_op_e;
endpackage

// File: rtl/shrot_linear.sv
module shrot_linear #(
  parameter int W  = 32,
  parameter int CW = 6
) (
  input  logic [W-1:0]  a,
  input  logic [CW-1:0] n,
  output logic [W-1:0]  shl_res,
  output logic          shl_c,
  output logic          shl_ovf,
  output logic [W-1:0]  shr_res,
  output logic          shr_c,
  output logic [W-1:0]  sar_res,
  output logic          sar_c
);
  localparam int NW = CW + 1;

  logic [NW-1:0]       n_ext;
  logic [NW-1:0]       n_lim;
  logic [NW-1:0]       n_sar;
  logic [W:0]          shl_t;
  logic [W:0]          shr_t;
  logic signed [W:0]   sar_t;
  logic [W-1:0]        diff;
  logic [W-1:0]        top_mask;

  assign n_ext = {1'b0, n};
  // distances past the word saturate one beyond it so even the carry empties
  assign n_lim = (n_ext > NW'(W)) ? NW'(W + 1) : n_ext;
  assign n_sar = (n_ext > NW'(W)) ? NW'(W) : n_ext;

  assign shl_t   = {1'b0, a} << n_lim;
  assign shl_res = shl_t[W-1:0];
  assign shl_c   = shl_t[W];

  assign shr_t   = {a, 1'b0} >> n_lim;
  assign shr_res = shr_t[W:1];
  assign shr_c   = shr_t[0];

  assign sar_t   = $signed({a, 1'b0}) >>> n_sar;
  assign sar_res = sar_t[W:1];
  assign sar_c   = sar_t[0];

  // overflow: the top n+1 bits of the operand must all match its sign
  assign diff     = a ^ {W{a[W-1]}};
  assign top_mask = (n_ext >= NW'(W)) ? {W{1'b1}} : ~({W{1'b1}} >> (n_ext + NW'(1)));

  always_comb begin
    if (n_ext == '0)
      shl_ovf = 1'b0;
    else if (n_ext >= NW'(W))
      shl_ovf = |a;
    else
      shl_ovf = |(diff & top_mask);
  end
endmodule

// File: rtl/shrot_rotate.sv
module shrot_rotate #(
  parameter int W  = 32,
  parameter int CW = 6
) (
  input  logic [W-1:0]  a,
  input  logic          cin,
  input  logic [CW-1:0] n,
  output logic [W-1:0]  rol_res,
  output logic          rol_c,
  output logic [W-1:0]  ror_res,
  output logic          ror_c,
  output logic [W-1:0]  rcl_res,
  output logic          rcl_c,
  output logic [W-1:0]  rcr_res,
  output logic          rcr_c
);
  localparam int LW = W + 1;

  logic [CW-1:0]     r_word;
  logic [CW-1:0]     r_loop;
  logic [2*W-1:0]    rol_t;
  logic [2*W-1:0]    ror_t;
  logic [LW-1:0]     loop_v;
  logic [2*LW-1:0]   rcl_t;
  logic [2*LW-1:0]   rcr_t;

  assign r_word = n % CW'(W);
  assign r_loop = n % CW'(LW);

  assign rol_t   = {a, a} << r_word;
  assign rol_res = rol_t[2*W-1:W];
  assign rol_c   = rol_t[W];

  assign ror_t   = {a, a} >> r_word;
  assign ror_res = ror_t[W-1:0];
  assign ror_c   = ror_t[W-1];

  // carry sits above the word as bit W of the loop
  assign loop_v  = {cin, a};
  assign rcl_t   = {loop_v, loop_v} << r_loop;
  assign rcl_res = rcl_t[2*LW-2:LW];
  assign rcl_c   = rcl_t[2*LW-1];

  assign rcr_t   = {loop_v, loop_v} >> r_loop;
  assign rcr_res = rcr_t[W-1:0];
  assign rcr_c   = rcr_t[W];
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int W     = 32,
  parameter int CW    = 6,
  parameter int CIN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     operand_i,
  input  logic [CIN_W-1:0] count_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic             carry_i,
  output logic [W-1:0]     result_o,
  output logic             carry_o,
  output logic             ovf_o
);
  logic [CW-1:0] n;
  logic [W-1:0]  shl_res, shr_res, sar_res, rol_res, ror_res, rcl_res, rcr_res;
  logic          shl_c, shr_c, sar_c, rol_c, ror_c, rcl_c, rcr_c, shl_ovf;
  logic [W-1:0]  res_d;
  logic          c_d;
  logic          ovf_d;

  assign n = count_i[CW-1:0];

  shrot_linear #(.W(W), .CW(CW)) u_linear (
    .a(operand_i), .n(n),
    .shl_res(shl_res), .shl_c(shl_c), .shl_ovf(shl_ovf),
    .shr_res(shr_res), .shr_c(shr_c),
    .sar_res(sar_res), .sar_c(sar_c)
  );

  shrot_rotate #(.W(W), .CW(CW)) u_rotate (
    .a(operand_i), .cin(carry_i), .n(n),
    .rol_res(rol_res), .rol_c(rol_c),
    .ror_res(ror_res), .ror_c(ror_c),
    .rcl_res(rcl_res), .rcl_c(rcl_c),
    .rcr_res(rcr_res), .rcr_c(rcr_c)
  );

  always_comb begin
    res_d = operand_i;
    c_d   = carry_i;
    ovf_d = 1'b0;
    if (n != '0) begin
      case (shrot_op_e'(op_i))
        OP_SHL:  begin res_d = shl_res; c_d = shl_c; ovf_d = shl_ovf; end
        OP_SHR:  begin res_d = shr_res; c_d = shr_c; end
        OP_SAR:  begin res_d = sar_res; c_d = sar_c; end
        OP_ROTL: begin res_d = rol_res; c_d = rol_c; end
        OP_ROTR: begin res_d = ror_res; c_d = ror_c; end
        OP_RCL:  begin res_d = rcl_res; c_d = rcl_c; end
        OP_RCR:  begin res_d = rcr_res; c_d = rcr_c; end
        default: begin res_d = operand_i; c_d = carry_i; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      carry_o  <= 1'b0;
      ovf_o    <= 1'b0;
    end else begin
      result_o <= res_d;
      carry_o  <= c_d;
      ovf_o    <= ovf_d;
    end
  end

  a_r2_zero_count: assert property (@(posedge clk) disable iff (rst)
    (count_i[CW-1:0] == '0) |=> (result_o == $past(operand_i) && carry_o == $past(carry_i) && !ovf_o));

  a_r8_ovf_left_only: assert property (@(posedge clk) disable iff (rst)
    (op_i != OP_SHL) |=> !ovf_o);

  a_r6_rotl_carry: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_ROTL && count_i[CW-1:0] != '0) |=> (carry_o == result_o[0]));

  a_r6_rotr_carry: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_ROTR && count_i[CW-1:0] != '0) |=> (carry_o == result_o[W-1]));

  a_r5_sar_sign: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SAR) |=> (result_o[W-1] == $past(operand_i[W-1])));

  a_r9_pass: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_PASS) |=> (result_o == $past(operand_i) && carry_o == $past(carry_i)));
endmodule

// File: tb/tb_shrot_unit.sv
module tb_shrot_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] operand_i = '0;
  logic [7:0]  count_i = '0;
  logic [2:0]  op_i = '0;
  logic        carry_i = 1'b0;
  logic [31:0] result_o;
  logic        carry_o;
  logic        ovf_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic        c;
    logic        ovf;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  shrot_unit dut (
    .clk(clk), .rst(rst), .operand_i(operand_i), .count_i(count_i),
    .op_i(op_i), .carry_i(carry_i), .result_o(result_o),
    .carry_o(carry_o), .ovf_o(ovf_o)
  );

  // reference: move one bit per step through the carry
  function automatic exp_t model(input logic [2:0] op, input logic [7:0] cnt,
                                 input logic [31:0] a, input logic ci);
    exp_t e;
    logic [31:0] v = a;
    logic        c = ci;
    logic        o = 1'b0;
    logic        nc;
    int          n = int'(cnt[5:0]);
    for (int i = 0; i < n; i++) begin
      case (op)
        3'd0: begin c = v[31]; if (c != a[31]) o = 1'b1; v = {v[30:0], 1'b0}; end
        3'd1: begin c = v[0]; v = {1'b0, v[31:1]}; end
        3'd2: begin c = v[0]; v = {v[31], v[31:1]}; end
        3'd3: begin c = v[31]; v = {v[30:0], v[31]}; end
        3'd4: begin c = v[0]; v = {v[0], v[31:1]}; end
        3'd5: begin nc = v[31]; v = {v[30:0], c}; c = nc; end
        3'd6: begin nc = v[0]; v = {c, v[31:1]}; c = nc; end
        default: ;
      endcase
    end
    if (op == 3'd0 && n != 0 && v[31] != a[31]) o = 1'b1;
    e.res = v; e.c = c; e.ovf = o; e.tag = "";
    return e;
  endfunction

  function automatic string tag_of(input logic [2:0] op, input logic [7:0] cnt);
    if (cnt[5:0] == 6'd0) return "R2";
    case (op)
      3'd0:       return "R4/R8";
      3'd1:       return "R4";
      3'd2:       return "R5";
      3'd3, 3'd4: return "R6";
      3'd5, 3'd6: return "R7";
      default:    return "R9";
    endcase
  endfunction

  task automatic drive(input logic [2:0] op, input logic [7:0] cnt,
                       input logic [31:0] a, input logic ci, input string tag);
    exp_t e;
    @(negedge clk);
    operand_i = a; count_i = cnt; op_i = op; carry_i = ci;
    e = model(op, cnt, a, ci);
    e.tag = (tag == "") ? tag_of(op, cnt) : tag;
    sb.push_back(e);
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (!rst && sb.size() > 0) begin
        e = sb.pop_front();
        n_cmp++;
        if (result_o !== e.res || carry_o !== e.c || ovf_o !== e.ovf) begin
          n_bad++;
          $display("FAIL %s: got res=%h c=%b ovf=%b, expected res=%h c=%b ovf=%b",
                   e.tag, result_o, carry_o, ovf_o, e.res, e.c, e.ovf);
        end
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: got hung run, expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state while reset is held with live inputs
    operand_i = 32'hFFFF_FFFF; count_i = 8'd3; op_i = 3'd3; carry_i = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    n_cmp++;
    if (result_o !== '0 || carry_o !== 1'b0 || ovf_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: got res=%h c=%b ovf=%b, expected res=0 c=0 ovf=0",
               result_o, carry_o, ovf_o);
    end
    @(negedge clk);
    rst = 1'b0;

    // R4/R8 left shift
    drive(3'd0, 8'd1,  32'h8000_0001, 1'b0, "R4/R8 shl1");
    drive(3'd0, 8'd1,  32'hC000_0000, 1'b0, "R8 no ovf");
    drive(3'd0, 8'd32, 32'h0000_0001, 1'b0, "R4 shl32");
    drive(3'd0, 8'd33, 32'hFFFF_FFFF, 1'b1, "R4 shl33");
    drive(3'd0, 8'd63, 32'h0000_0000, 1'b1, "R4/R8 shl63 zero");
    drive(3'd0, 8'd31, 32'hFFFF_FFFF, 1'b0, "R8 shl31 sign ones");
    // R4 right shift
    drive(3'd1, 8'd4,  32'h8000_000F, 1'b0, "R4 shr4");
    drive(3'd1, 8'd32, 32'h8000_0000, 1'b0, "R4 shr32");
    drive(3'd1, 8'd40, 32'hFFFF_FFFF, 1'b1, "R4 shr40");
    // R5 arithmetic right
    drive(3'd2, 8'd31, 32'h8000_0000, 1'b0, "R5 sar31");
    drive(3'd2, 8'd32, 32'h8000_0001, 1'b0, "R5 sar32 neg");
    drive(3'd2, 8'd50, 32'h7FFF_FFFF, 1'b1, "R5 sar50 pos");
    // R6 rotates
    drive(3'd3, 8'd1,  32'h8000_0000, 1'b0, "R6 rotl1");
    drive(3'd3, 8'd32, 32'h1234_5679, 1'b0, "R6 rotl32");
    drive(3'd4, 8'd4,  32'h1234_5678, 1'b1, "R6 rotr4");
    drive(3'd4, 8'd36, 32'h8765_4321, 1'b0, "R6 rotr36");
    // R7 through carry
    drive(3'd5, 8'd1,  32'h8000_0000, 1'b1, "R7 rcl1");
    drive(3'd5, 8'd33, 32'hDEAD_BEEF, 1'b1, "R7 rcl33 identity");
    drive(3'd5, 8'd32, 32'h0000_0001, 1'b0, "R7 rcl32");
    drive(3'd6, 8'd1,  32'h0000_0001, 1'b0, "R7 rcr1");
    drive(3'd6, 8'd34, 32'hA5A5_0F0F, 1'b1, "R7 rcr34");
    // R2 zero count on every code
    for (int k = 0; k < 8; k++)
      drive(3'(k), 8'd0, 32'hF00D_8001, 1'b1, "R2 zero count");
    // R3 upper count bits ignored
    drive(3'd0, 8'h40, 32'h8000_0001, 1'b0, "R3 cnt 0x40");
    drive(3'd0, 8'h41, 32'h8000_0001, 1'b0, "R3 cnt 0x41");
    drive(3'd4, 8'hC3, 32'h0000_00F0, 1'b0, "R3 cnt 0xC3");
    // R9 pass
    drive(3'd7, 8'd5, 32'h1357_9BDF, 1'b1, "R9 pass");
    // random sweep
    for (int k = 0; k < 600; k++)
      drive(3'($urandom_range(0, 7)), 8'($urandom), $urandom, 1'($urandom), "");
    repeat (3) @(posedge clk);
    #2;
    finish_run();
  end
endmodule